// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital control core of a successive-approximation converter. Software programs it through a small word-wide register port. One register selects the channel and arms the interrupt. One holds the timing, averaging, resolution and overwrite options. One enables averaging and free-running repetition. The remaining two report status and hand back the result. Each conversion is timed in converter-clock ticks (`adc_tick`). A conversion is a fixed start phase followed by one or more base periods. At the end of each base period the digitised value on `sample_in` is captured. Those captures are summed and divided by their count with a right shift.

The finished value is trimmed to the selected resolution and latched into the result register, and the completion flag is raised. The interrupt line follows that flag while interrupts are armed. Reading the result lowers both. With repetition enabled, the next conversion begins on the tick that ends the previous one.

`sample_in` is a plain data port with no handshake. The block samples it on the final tick of every base period, and the source must hold a valid code there; no back-pressure exists on either side. The register port completes every access in one cycle, and reads are combinational.

Top module: `adc_seq_core`

## Requirements
- R1: A conversion lasts exactly 6 + N×(25 + L) ticks of `adc_tick`, counted from the control write. The completion flag is visible after the tick that ends it.
- R2: N is 1 when averaging (GCTL bit 0) is clear. When it is set, CFG bits 6:5 give N = 4, 8, 16, 32 for codes 0..3.
- R3: L depends on CFG bit 4 and CFG bits 3:2. With bit 4 clear, codes 0..3 give 3, 5, 7, 9. With bit 4 set, codes 0..3 give 13, 17, 21, 25.
- R4: Writing CTRL with bits 4:0 other than 0x1F starts a conversion. Writing 0x1F stops the block: there is no completion, busy (STAT bit 1) reads 0, and the control register reads back 0x1F.
- R5: On completion, STAT bit 0 is set. `irq` is high exactly while that flag is set and CTRL bit 7 is 1.
- R6: CFG bits 1:0 select 8, 10 or 12 result bits for codes 0, 1, 2 (code 3 is also 12). The stored result is masked to 0xFF, 0x3FF or 0xFFF.
- R7: The result is the sum of the N captured samples shifted right by log2(N). A sample is captured on the last tick of each base period.
- R8: With GCTL bit 1 set, a new conversion starts on the tick that completes the previous one, until repetition is cleared or the block is stopped.
- R9: If the flag is still set when a conversion completes, the result is replaced when CFG bit 7 is 1 and kept when it is 0.
- R10: A read of RES (address 4) clears the completion flag and lowers `irq`.
- R11: A CTRL write during a conversion abandons it and restarts timing from that write.
- R12: After reset: channel 0x1F, flag, busy and result are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_tick | input | 1 | Converter clock enable, one tick per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register address: 0 CTRL, 1 CFG, 2 GCTL, 3 STAT, 4 RES |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| sample_in | input | 12 | Digitised value from the analog stage |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its defaults: 12-bit samples, base time 25, start adder 6, up to 32 averaged samples. It holds `adc_tick` high so that ticks equal clock cycles. This makes a full sweep practical. All eight long-sample settings are run with averaging off and with each of the four average counts, for 40 conversions of up to 1606 cycles. A sample input that changes every cycle means a capture on the wrong tick, or a wrong shift, shows up in the averaged result. Each resolution, overwrite policy, repetition, abort and stop is then driven on the short 34-tick conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BASE} phase_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_GCTL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_RES  = 3'd4;

  typedef struct packed {
    logic       ovwr;
    logic [1:0] avgsel;
    logic       lsmp;
    logic [1:0] sts;
    logic [1:0] res;
  } cfg_t;

  function automatic logic [5:0] lst_adder(input logic lsmp, input logic [1:0] sts);
    if (!lsmp) return 6'd3 + {3'd0, sts, 1'b0};
    else if (sts == 2'd3) return 6'd25;
    else return 6'd13 + {2'd0, sts, 2'b00};
  endfunction

  function automatic logic [2:0] avg_log(input logic en, input logic [1:0] sel);
    return en ? (3'd2 + {1'b0, sel}) : 3'd0;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int START_ADD = 6,
  parameter int CNT_W     = 6,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             cont,
  input  logic [CNT_W-1:0] blen_in,
  input  logic [2:0]       nlog_in,
  output logic             busy,
  output logic             strobe,
  output logic             first,
  output logic             last,
  output logic [2:0]       nlog_q
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, blen_q;
  logic [IDX_W-1:0] idx_q;
  logic             n_last, base_end;

  assign n_last   = idx_q == ((IDX_W'(1) << nlog_q) - IDX_W'(1));
  assign base_end = cnt_q == blen_q - CNT_W'(1);
  assign busy     = phase_q != PH_IDLE;
  assign strobe   = (phase_q == PH_BASE) && tick && base_end;
  assign first    = strobe && (idx_q == '0);
  assign last     = strobe && n_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      blen_q  <= CNT_W'(1);
      nlog_q  <= '0;
    end else if (start) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
      idx_q   <= '0;
      blen_q  <= blen_in;
      nlog_q  <= nlog_in;
    end else if (stop) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (tick) begin
      case (phase_q)
        PH_START: begin
          if (cnt_q == CNT_W'(START_ADD - 1)) begin
            phase_q <= PH_BASE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_BASE: begin
          if (base_end) begin
            cnt_q <= '0;
            if (n_last) begin
              idx_q <= '0;
              if (cont) begin
                phase_q <= PH_START;
                blen_q  <= blen_in;
                nlog_q  <= nlog_in;
              end else begin
                phase_q <= PH_IDLE;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == PH_START && cnt_q == '0));

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (phase_q == PH_IDLE));

  // R1
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BASE) |-> (cnt_q < blen_q));

endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                first,
  input  logic [2:0]          nlog,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] avg
);

  localparam int ACC_W = SAMPLE_W + MAX_LOG;

  logic [ACC_W-1:0] acc_q, sum, shifted;
  logic             unused_hi;

  assign sum       = (first ? '0 : acc_q) + ACC_W'(sample);
  assign shifted   = sum >> nlog;
  assign avg       = shifted[SAMPLE_W-1:0];
  assign unused_hi = ^shifted[ACC_W-1:SAMPLE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (strobe) acc_q <= sum;
  end

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && first) |=> (acc_q == ACC_W'($past(sample))));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int BASE_T   = 25,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                rd,
  input  logic [2:0]          addr,
  input  logic [15:0]         wdata,
  output logic [15:0]         rdata,
  input  logic                busy,
  input  logic                finish,
  input  logic [SAMPLE_W-1:0] avg,
  output logic                start,
  output logic                stop,
  output logic                cont,
  output logic [CNT_W-1:0]    blen,
  output logic [2:0]          nlog,
  output logic                irq
);

  localparam logic [4:0] CH_OFF = 5'h1F;

  logic [4:0]          chan_q;
  logic                ie_q, avg_en_q, cont_q, done_q;
  cfg_t                cfg_q;
  logic [SAMPLE_W-1:0] result_q, mask;
  logic                wr_ctrl, rd_res, unused_wbits;

  assign unused_wbits = ^wdata[15:8];
  assign wr_ctrl = wr && addr == A_CTRL;
  assign rd_res  = rd && addr == A_RES;
  assign start   = wr_ctrl && wdata[4:0] != CH_OFF;
  assign stop    = wr_ctrl && wdata[4:0] == CH_OFF;
  assign cont    = cont_q;
  assign blen    = CNT_W'(BASE_T) + CNT_W'(lst_adder(cfg_q.lsmp, cfg_q.sts));
  assign nlog    = avg_log(avg_en_q, cfg_q.avgsel);
  assign irq     = done_q && ie_q;

  always_comb begin
    case (cfg_q.res)
      2'd0:    mask = {{4{1'b0}}, {(SAMPLE_W-4){1'b1}}};
      2'd1:    mask = {{2{1'b0}}, {(SAMPLE_W-2){1'b1}}};
      default: mask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= CH_OFF;
      ie_q     <= 1'b0;
      cfg_q    <= '0;
      avg_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_CTRL: begin chan_q <= wdata[4:0]; ie_q <= wdata[7]; end
        A_CFG:  cfg_q <= cfg_t'(wdata[7:0]);
        A_GCTL: begin avg_en_q <= wdata[0]; cont_q <= wdata[1]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else if (finish) begin
      done_q <= 1'b1;
      if (!done_q || cfg_q.ovwr) result_q <= avg & mask;
    end else if (rd_res) begin
      done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = {8'd0, ie_q, 2'b00, chan_q};
      A_CFG:  rdata = {8'd0, cfg_q};
      A_GCTL: rdata = {14'd0, cont_q, avg_en_q};
      A_STAT: rdata = {14'd0, busy, done_q};
      A_RES:  rdata = 16'(result_q);
      default: rdata = '0;
    endcase
  end

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !finish) |=> !done_q);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg_q.ovwr) |=> $stable(result_q));

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
  parameter int SAMPLE_W  = 12,
  parameter int START_ADD = 6,
  parameter int BASE_T    = 25,
  parameter int MAX_LOG   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adc_tick,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [2:0]          bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                irq
);

  localparam int CNT_W = $clog2(BASE_T + 25 + 1);
  localparam int IDX_W = MAX_LOG + 1;

  logic             start, stop, cont, busy, strobe, first, last;
  logic [CNT_W-1:0] blen;
  logic [2:0]       nlog_cfg, nlog_run;
  logic [SAMPLE_W-1:0] avg;

  adc_seq_regs #(.SAMPLE_W(SAMPLE_W), .BASE_T(BASE_T), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .finish(last),
    .avg(avg), .start(start), .stop(stop), .cont(cont), .blen(blen),
    .nlog(nlog_cfg), .irq(irq)
  );

  adc_seq_timer #(.START_ADD(START_ADD), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(adc_tick), .start(start), .stop(stop),
    .cont(cont), .blen_in(blen), .nlog_in(nlog_cfg), .busy(busy),
    .strobe(strobe), .first(first), .last(last), .nlog_q(nlog_run)
  );

  adc_seq_accum #(.SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG)) u_accum (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .first(first),
    .nlog(nlog_run), .sample(sample_in), .avg(avg)
  );

endmodule

// File: tb/test_adc_seq_core.sv
`timescale 1ns/1ps
module test_adc_seq_core;

  logic        clk = 1'b0, rst_n = 1'b0, adc_tick = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [11:0] sample_in;
  logic        irq;
  int          tcyc = 0;
  int          t_wr = 0;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tcyc <= tcyc + 1;

  function automatic int fsamp(input int t);
    return (t * 37 + 5) & 12'hFFF;
  endfunction
  assign sample_in = 12'(fsamp(tcyc));

  adc_seq_core i_adc_seq_core (
    .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sample_in(sample_in), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    t_wr = tcyc;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1; #1;
    v = int'(bus_rdata);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    bus_addr = a; #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic int ladd(input int l, input int s);
    if (l == 0) return 3 + 2 * s;
    return (s == 3) ? 25 : 13 + 4 * s;
  endfunction

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, cyc, b, n, tt, sum, ex, a1, a2, sel_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    peek(3'd3, v); check(v == 0, "R12 status", v, 0);
    peek(3'd4, v); check(v == 0, "R12 result", v, 0);
    peek(3'd0, v); check(v == 'h1F, "R12 channel", v, 'h1F);
    check(irq == 1'b0, "R12 irq", irq, 0);

    // R1 R2 R3 R7 sweep of timing and averaging
    for (int en = 0; en < 2; en++) begin
      sel_hi = en ? 3 : 0;
      for (int sel = 0; sel <= sel_hi; sel++) begin
        for (int l = 0; l < 2; l++) begin
          for (int s = 0; s < 4; s++) begin
            wr_reg(3'd1, 16'(128 + sel * 32 + l * 16 + s * 4 + 2));
            wr_reg(3'd2, 16'(en));
            wr_reg(3'd0, 16'h0083);
            b  = 25 + ladd(l, s);
            n  = en ? (4 << sel) : 1;
            tt = 6 + n * b;
            wait_irq(cyc);
            check(cyc == tt, "R1 R2 R3 conversion length", cyc, tt);
            sum = 0;
            for (int k = 1; k <= n; k++) sum += fsamp(t_wr + 6 + k * b);
            ex = (sum >> (en ? 2 + sel : 0)) & 'hFFF;
            rd_reg(3'd4, v);
            check(v == ex, "R7 averaged result", v, ex);
            check(irq == 1'b0, "R10 irq after read", irq, 0);
          end
        end
      end
    end

    // R6 resolution masks
    wr_reg(3'd2, 16'h0000);
    for (int r = 0; r < 4; r++) begin
      wr_reg(3'd1, 16'(128 + r));
      wr_reg(3'd0, 16'h0081);
      wait_irq(cyc);
      ex = fsamp(t_wr + 34) & (r == 0 ? 'hFF : r == 1 ? 'h3FF : 'hFFF);
      rd_reg(3'd4, v);
      check(v == ex, "R6 resolution mask", v, ex);
    end

    // R5 R9 overwrite disabled, interrupt disarmed
    wr_reg(3'd1, 16'h0002);
    wr_reg(3'd0, 16'h0003);
    a1 = t_wr;
    repeat (34) @(negedge clk);
    peek(3'd3, v); check((v & 1) == 1, "R5 done flag", v & 1, 1);
    check(irq == 1'b0, "R5 irq disarmed", irq, 0);
    wr_reg(3'd0, 16'h0003);
    repeat (34) @(negedge clk);
    peek(3'd4, v); ex = fsamp(a1 + 34);
    check(v == ex, "R9 result kept", v, ex);
    rd_reg(3'd4, v);
    peek(3'd3, v); check((v & 1) == 0, "R10 done cleared", v & 1, 0);

    // R9 overwrite enabled
    wr_reg(3'd1, 16'h0082);
    wr_reg(3'd0, 16'h0003);
    repeat (34) @(negedge clk);
    wr_reg(3'd0, 16'h0003);
    a2 = t_wr;
    repeat (34) @(negedge clk);
    peek(3'd4, v); ex = fsamp(a2 + 34);
    check(v == ex, "R9 result replaced", v, ex);
    rd_reg(3'd4, v);

    // R11 abort and restart
    wr_reg(3'd0, 16'h0083);
    repeat (10) @(negedge clk);
    check(irq == 1'b0, "R11 no early irq", irq, 0);
    wr_reg(3'd0, 16'h0085);
    a2 = t_wr;
    wait_irq(cyc);
    check(cyc == 34, "R11 restart timing", cyc, 34);
    rd_reg(3'd4, v); ex = fsamp(a2 + 34);
    check(v == ex, "R11 restart result", v, ex);

    // R8 continuous conversion
    wr_reg(3'd2, 16'h0002);
    wr_reg(3'd0, 16'h0003);
    a1 = t_wr;
    repeat (34) @(negedge clk);
    peek(3'd4, v); ex = fsamp(a1 + 34);
    check(v == ex, "R8 first result", v, ex);
    peek(3'd3, v); check((v & 2) == 2, "R8 still busy", v & 2, 2);
    repeat (34) @(negedge clk);
    peek(3'd4, v); ex = fsamp(a1 + 68);
    check(v == ex, "R8 second result", v, ex);
    wr_reg(3'd2, 16'h0000);

    // R4 stop
    wr_reg(3'd0, 16'h001F);
    rd_reg(3'd4, v);
    wr_reg(3'd0, 16'h0083);
    repeat (5) @(negedge clk);
    wr_reg(3'd0, 16'h009F);
    repeat (80) @(negedge clk);
    check(irq == 1'b0, "R4 no completion after stop", irq, 0);
    peek(3'd3, v); check(v == 0, "R4 idle status", v, 0);
    peek(3'd0, v); check((v & 'h1F) == 'h1F, "R4 stop channel", v & 'h1F, 'h1F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule